// File: doc/BRIEF.md
# Residual Add-and-Clamp Reconstruction for a 32x32 Block

This block closes out a two-pass inverse transform. For each group it takes four rows of eight signed 16-bit residuals, divides each by 64 with round-half-up, adds the result to the matching 8-bit prediction pixel and writes the pixel back, clamped to 0..255. It fetches the four prediction rows itself through a read port with a fixed one-cycle latency. Only after all four have been captured does it emit the four reconstructed rows on a write port.

The block also owns the row and column walk over a 32x32 tile. Within each 8-column band, groups alternate between two streams. The centre stream starts at the middle rows and moves outward. The extreme stream starts at the top and bottom rows and moves inward. Each stream moves two rows per group, so eight groups cover all 32 rows of a band. After eight groups the column advances by 8. After four bands the walk returns to the first band, and the next group takes a fresh base column.

The controller has four states. IDLE waits for a group. READ issues four prediction reads. WAIT lets the last read return. WRITE emits four pixel rows. The transitions are: accept (IDLE to READ on `res_vld`), reads_done (READ to WAIT after the fourth read), drain (WAIT to WRITE, unconditional) and group_done (WRITE to IDLE after the fourth write).

Top module: `pix_recon`

## Requirements
- R1: Each residual is rounded and scaled as (res + 32) >>> 6, computed without 16-bit overflow, so 32767 gives 512 and -32768 gives -512.
- R2: The scaled residual is added to the prediction pixel, which is treated as unsigned (zero-extended).
- R3: The sum is saturated: below 0 gives 0, above 255 gives 255, and any other value passes through unchanged.
- R4: A centre group with index k (k = 0..3 within the band) uses the row order 16+2k, 17+2k, 15-2k, 14-2k for slots 0..3.
- R5: An extreme group with index k uses the row order 2k, 2k+1, 31-2k, 30-2k for slots 0..3.
- R6: Within a band the groups run centre0, extreme0, centre1, extreme1, and so on, for eight groups in total, so every row 0..31 is written exactly once per band.
- R7: A group issues four reads, in slot order 0..3 on consecutive cycles, and then four writes in the same slot order. `rd_data` is valid one cycle after `rd_en`. Pixel j sits at `rd_data`/`wr_data` bits [8j+7:8j]. The residual for slot s, pixel j sits at `res_vec` bits [(8s+j)*16+15:(8s+j)*16].
- R8: The column on `rd_col` and `wr_col` equals the base column plus 8 times the band (0..3). The band advances after eight groups and wraps to 0 after four bands. `base_col` is sampled only when the first group of a tile is accepted.
- R9: `grp_ready` is high only in IDLE. While it is low, `res_vld` and `res_vec` are ignored.
- R10: After reset `grp_ready` is 1, `rd_en` and `wr_en` are 0, and the walk starts at centre group 0 of band 0.
- R11: No row is written in a group before that row has been read in the same group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_vld | input | 1 | Residual group offered |
| res_vec | input | 512 | Four slots of eight signed 16-bit residuals |
| base_col | input | 8 | Column of the tile's left edge |
| grp_ready | output | 1 | Block idle, group will be accepted |
| rd_en | output | 1 | Prediction read request |
| rd_row | output | 5 | Row of the read |
| rd_col | output | 8 | First column of the read |
| rd_data | input | 64 | Eight prediction pixels, one cycle after rd_en |
| wr_en | output | 1 | Reconstructed row write |
| wr_row | output | 5 | Row of the write |
| wr_col | output | 8 | First column of the write |
| wr_data | output | 64 | Eight clamped pixels |

## Verification
The hardest case to reach from the ports is a residual offer that arrives while a group is in flight. It must change neither the latched residuals nor the walk. The stimulus forces this case in one group: it raises `res_vld` with saturating garbage while the block is in READ, and then checks that every pixel of the tile still matches the reference. Rounding and clamp edges (half-step values, exact 0 and 255, the 16-bit extremes) are placed at pixel positions spread over all rows. A mis-ordered row walk therefore shows up as wrong pixels, and not only as a wrong address log.

// File: rtl/recon_pkg.sv
package recon_pkg;
    localparam int SLOTS = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WRITE = 2'd3
    } recon_st_t;

    // round-half-up divide by 64, add unsigned pixel, saturate to a byte
    function automatic logic [7:0] add_clamp(input logic [15:0] res, input logic [7:0] pix);
        logic signed [16:0] wide;
        logic signed [16:0] shifted;
        logic signed [11:0] sum;
        wide    = $signed({res[15], res}) + 17'sd32;
        shifted = wide >>> 6;
        sum     = $signed(shifted[11:0]) + $signed({4'b0000, pix});
        if (sum[11])
            return 8'd0;
        else if (sum[10:8] != 3'd0)
            return 8'd255;
        else
            return sum[7:0];
    endfunction
endpackage

// File: rtl/recon_lanes.sv
module recon_lanes #(
    parameter int LANES = 8
) (
    input  logic [LANES*16-1:0] res_row,
    input  logic [LANES*8-1:0]  pred_row,
    output logic [LANES*8-1:0]  pix_row
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign pix_row[j*8 +: 8] = recon_pkg::add_clamp(res_row[j*16 +: 16], pred_row[j*8 +: 8]);
    end
endmodule

// File: rtl/recon_row_walk.sv
module recon_row_walk #(
    parameter int ROWS  = 32,
    parameter int LANES = 8,
    parameter int CW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic [1:0]               slot,
    output logic [$clog2(ROWS)-1:0]  row,
    output logic [CW-1:0]            col_off,
    output logic                     blk_first
);
    localparam int RW    = $clog2(ROWS);
    localparam int GPB   = ROWS / 4;
    localparam int GW    = $clog2(GPB);
    localparam int BANDS = ROWS / LANES;
    localparam int BW    = (BANDS > 1) ? $clog2(BANDS) : 1;
    localparam int HALF  = ROWS / 2;

    logic [GW-1:0] gidx;
    logic [BW-1:0] band;
    logic          ext;
    logic [RW-1:0] two_k, p_row, q_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gidx <= '0;
            band <= '0;
        end else if (adv) begin
            if (gidx == GW'(GPB - 1)) begin
                gidx <= '0;
                band <= (band == BW'(BANDS - 1)) ? '0 : band + 1'b1;
            end else begin
                gidx <= gidx + 1'b1;
            end
        end
    end

    always_comb begin
        ext   = gidx[0];
        two_k = RW'(gidx >> 1) << 1;
        p_row = ext ? two_k : RW'(HALF) + two_k;
        q_row = ext ? RW'(ROWS - 1) - two_k : RW'(HALF - 1) - two_k;
        unique case (slot)
            2'd0:    row = p_row;
            2'd1:    row = p_row + 1'b1;
            2'd2:    row = q_row;
            default: row = q_row - 1'b1;
        endcase
        col_off   = CW'(band) * CW'(LANES);
        blk_first = (gidx == '0) && (band == '0);
    end
endmodule

// File: rtl/pix_recon.sv
module pix_recon #(
    parameter int ROWS  = 32,
    parameter int LANES = 8,
    parameter int CW    = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   res_vld,
    input  logic [recon_pkg::SLOTS*LANES*16-1:0]   res_vec,
    input  logic [CW-1:0]                          base_col,
    output logic                                   grp_ready,
    output logic                                   rd_en,
    output logic [$clog2(ROWS)-1:0]                rd_row,
    output logic [CW-1:0]                          rd_col,
    input  logic [LANES*8-1:0]                     rd_data,
    output logic                                   wr_en,
    output logic [$clog2(ROWS)-1:0]                wr_row,
    output logic [CW-1:0]                          wr_col,
    output logic [LANES*8-1:0]                     wr_data
);
    import recon_pkg::*;

    localparam int RW   = $clog2(ROWS);
    localparam int ROWB = LANES * 16;

    recon_st_t              st, st_nxt;
    logic [1:0]             step;
    logic                   rd_pend;
    logic [1:0]             pend_slot;
    logic [LANES*8-1:0]     pred_q [SLOTS];
    logic [SLOTS*ROWB-1:0]  res_q;
    logic [CW-1:0]          base_q;
    logic                   adv, blk_first;
    logic [RW-1:0]          cur_row;
    logic [CW-1:0]          col_off;
    logic [LANES*8-1:0]     pix_row;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // outputs and next state
    always_comb begin
        st_nxt    = st;
        grp_ready = 1'b0;
        rd_en     = 1'b0;
        wr_en     = 1'b0;
        unique case (st)
            ST_IDLE: begin
                grp_ready = 1'b1;
                if (res_vld) st_nxt = ST_READ;
            end
            ST_READ: begin
                rd_en = 1'b1;
                if (step == 2'(SLOTS - 1)) st_nxt = ST_WAIT;
            end
            ST_WAIT: st_nxt = ST_WRITE;
            ST_WRITE: begin
                wr_en = 1'b1;
                if (step == 2'(SLOTS - 1)) st_nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step      <= '0;
            rd_pend   <= 1'b0;
            pend_slot <= '0;
            res_q     <= '0;
            base_q    <= '0;
            for (int s = 0; s < SLOTS; s++) pred_q[s] <= '0;
        end else begin
            if (st != st_nxt)          step <= '0;
            else if (rd_en || wr_en)   step <= step + 1'b1;
            rd_pend   <= rd_en;
            pend_slot <= step;
            if (rd_pend) pred_q[pend_slot] <= rd_data;
            if (grp_ready && res_vld) begin
                res_q <= res_vec;
                if (blk_first) base_q <= base_col;
            end
        end
    end

    assign adv = wr_en && (step == 2'(SLOTS - 1));

    recon_row_walk #(.ROWS(ROWS), .LANES(LANES), .CW(CW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .slot      (step),
        .row       (cur_row),
        .col_off   (col_off),
        .blk_first (blk_first)
    );

    recon_lanes #(.LANES(LANES)) u_lanes (
        .res_row  (res_q[step*ROWB +: ROWB]),
        .pred_row (pred_q[step]),
        .pix_row  (pix_row)
    );

    assign rd_row  = cur_row;
    assign wr_row  = cur_row;
    assign rd_col  = base_q + col_off;
    assign wr_col  = base_q + col_off;
    assign wr_data = pix_row;
endmodule

// File: rtl/pix_recon_chk.sv
module pix_recon_chk #(
    parameter int ROWS = 32,
    parameter int CW   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     res_vld,
    input logic                     grp_ready,
    input logic                     rd_en,
    input logic [$clog2(ROWS)-1:0]  rd_row,
    input logic                     wr_en,
    input logic [$clog2(ROWS)-1:0]  wr_row,
    input logic [CW-1:0]            wr_col
);
    logic [2:0]      rd_cnt;
    logic [ROWS-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            seen   <= '0;
        end else if (grp_ready && res_vld) begin
            rd_cnt <= '0;
            seen   <= '0;
        end else if (rd_en) begin
            rd_cnt       <= rd_cnt + 1'b1;
            seen[rd_row] <= 1'b1;
        end
    end

    AST_FOUR_READS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rd_cnt == 3'd4);                                        // R7
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !wr_en);                                                // R7
    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> seen[wr_row]);                                          // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        grp_ready |-> (!rd_en && !wr_en));                                // R9
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> wr_col == $past(wr_col));             // R8
endmodule

bind pix_recon pix_recon_chk #(.ROWS(ROWS), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_vld   (res_vld),
    .grp_ready (grp_ready),
    .rd_en     (rd_en),
    .rd_row    (rd_row),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_col    (wr_col)
);

// File: tb/pix_recon_bench.sv
module pix_recon_bench;
    localparam int NT = 14;
    localparam int T_RES  [NT] = '{0, 31, 32, -32, -33, -97, 32767, -32768, 6400, -6400, 640, -640, 64, -192};
    localparam int T_PRED [NT] = '{100, 100, 100, 100, 100, 100, 0, 255, 200, 50, 245, 10, 254, 3};
    localparam int T_EXP  [NT] = '{100, 100, 101, 100, 99, 98, 255, 0, 255, 0, 255, 0, 255, 0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         res_vld = 1'b0;
    logic [511:0] res_vec = '0;
    logic [7:0]   base_col = '0;
    logic         grp_ready, rd_en, wr_en;
    logic [4:0]   rd_row, wr_row;
    logic [7:0]   rd_col, wr_col;
    logic [63:0]  rd_data = '0;
    logic [63:0]  wr_data;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int order_err = 0;
    bit done = 0;
    logic [7:0] cur_base = '0;
    logic [7:0] out_mem [32][32];
    logic [4:0] wr_log  [128];
    logic [7:0] col_log [128];
    bit         rd_seen [32];

    always #5 clk = ~clk;

    pix_recon u_pix_recon (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_vec(res_vec),
        .base_col(base_col), .grp_ready(grp_ready), .rd_en(rd_en),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
    );

    function automatic int tidx(int r, int c);
        return (r * 3 + c) % NT;
    endfunction

    function automatic int exp_row(int gb, int s);
        int k, p, q;
        k = gb / 2;
        p = (gb % 2) ? 2 * k : 16 + 2 * k;
        q = (gb % 2) ? 31 - 2 * k : 15 - 2 * k;
        case (s)
            0: return p;
            1: return p + 1;
            2: return q;
            default: return q - 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // prediction memory with one-cycle latency and write capture
    always @(posedge clk) begin
        if (rd_en) begin
            for (int j = 0; j < 8; j++)
                rd_data[j*8 +: 8] <= 8'(T_PRED[tidx(rd_row, int'(8'(rd_col - cur_base)) + j)]);
            rd_seen[rd_row] = 1'b1;
            rd_cnt++;
        end
        if (wr_en) begin
            if (!rd_seen[wr_row]) order_err++;
            for (int j = 0; j < 8; j++)
                out_mem[wr_row][5'(8'(wr_col - cur_base)) + 5'(j)] = wr_data[j*8 +: 8];
            if (wr_cnt < 128) begin
                wr_log[wr_cnt]  = wr_row;
                col_log[wr_cnt] = wr_col;
            end
            wr_cnt++;
        end
    end

    task automatic run_tile(input logic [7:0] base);
        logic [511:0] vec;
        wr_cnt = 0;
        rd_cnt = 0;
        order_err = 0;
        cur_base = base;
        for (int g = 0; g < 32; g++) begin
            for (int s = 0; s < 4; s++)
                for (int j = 0; j < 8; j++)
                    vec[(s*8+j)*16 +: 16] = 16'(T_RES[tidx(exp_row(g % 8, s), (g / 8) * 8 + j)]);
            @(negedge clk);
            while (!grp_ready) @(negedge clk);
            for (int r = 0; r < 32; r++) rd_seen[r] = 1'b0;
            res_vld  = 1'b1;
            res_vec  = vec;
            base_col = base;
            @(negedge clk);
            res_vld  = 1'b0;
            base_col = 8'hEE;
            if (g == 5) begin
                @(negedge clk);
                check(grp_ready == 1'b0, "R9 busy", grp_ready, 0);
                res_vld = 1'b1;
                res_vec = {32{16'h7FFF}};
                @(negedge clk);
                res_vld = 1'b0;
            end
        end
        @(negedge clk);
        while (!grp_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_tile(input logic [7:0] base);
        int n;
        check(wr_cnt == 128, "R6 write count", wr_cnt, 128);
        check(rd_cnt == 128, "R7 read count", rd_cnt, 128);
        check(order_err == 0, "R11 read before write", order_err, 0);
        n = 0;
        for (int i = 0; i < 128; i++)
            if (wr_log[i] != 5'(exp_row((i / 4) % 8, i % 4))) begin
                if (((i / 4) % 2) == 0) check(0, "R4 centre row", wr_log[i], exp_row((i / 4) % 8, i % 4));
                else                    check(0, "R5 extreme row", wr_log[i], exp_row((i / 4) % 8, i % 4));
                n++;
            end
        check(n == 0, "R4 R5 R6 row walk", n, 0);
        n = 0;
        for (int i = 0; i < 128; i++)
            if (col_log[i] != 8'(base + 8 * (i / 32))) n++;
        check(n == 0, "R8 column walk", n, 0);
        check(col_log[0] == base, "R8 base column", col_log[0], base);
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++)
                check(out_mem[r][c] == 8'(T_EXP[tidx(r, c)]), "R1 R2 R3 R7 pixel",
                      out_mem[r][c], T_EXP[tidx(r, c)]);
    endtask

    initial begin
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++) out_mem[r][c] = 8'hXX;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(grp_ready == 1'b1, "R10 ready", grp_ready, 1);
        check(rd_en == 1'b0, "R10 rd_en", rd_en, 0);
        check(wr_en == 1'b0, "R10 wr_en", wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_tile(8'd16);
        check_tile(8'd16);
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++) out_mem[r][c] = 8'hXX;
        run_tile(8'd200);
        check_tile(8'd200);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule